// File: doc/BRIEF.md
# Repeating Status Byte Streamer

This block is the device-side answer to a serial status-read command. A host selects the device by pulling chip select low. It then clocks in an 8-bit command, most significant bit first, with data taken on rising SCK edges. If the command is one of the two status-read codes, the block drives an 8-bit status byte on the serial output. Each bit changes on a falling SCK edge, so the host can take it on the following rising edge.

The byte repeats for as long as SCK keeps toggling. Each repetition is rebuilt from the live busy flag and the live compare-result flag, next to a fixed density code. The ready bit is the first bit of every repetition. While that bit is presented it follows the busy flag directly. A host can therefore park SCK low after the ready bit and watch the output rise when the device becomes ready.

All serial pins are sampled through synchronizers on a fast system clock. The output enable stands in for a tri-state driver.

Top module: `stat_stream`

## Requirements
- R1: After reset, and while no selection is active, so_oe is 0 and so is 0.
- R2: The stream starts only when the 8 command bits received after chip select falls equal 8'h57 or 8'hD7. For any other command, so_oe stays 0 until chip select rises.
- R3: After a matching command, so_oe rises on the first falling SCK edge after the 8th rising edge, and status bit 7 is presented. Each later falling edge presents the next lower bit.
- R4: Bit 7 is 1 when busy is 0 (ready) and 0 when busy is 1. Bit 6 equals cmp_diff: 0 when the last compare matched, 1 when it differed.
- R5: Bits 5 down to 2 carry the density code 1,0,1,1 in that order. Bits 1 and 0 are driven as 0.
- R6: After bit 0, the next falling edge presents bit 7 again. Bits 6 down to 0 of each repetition are captured from the live inputs on the falling edge that starts bit 6.
- R7: While bit 7 is presented, so follows the inverted busy input with no SCK edge needed, so a parked SCK shows busy ending as so going from 0 to 1.
- R8: Within SYNC_STAGES+2 system clocks of chip select rising, so_oe is 0. The next selection starts again at command reception and bit 7.
- R9: Changes of busy or cmp_diff while bits 6 down to 0 are presented have no effect on those bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial command input, taken on rising SCK |
| busy | input | 1 | Busy flag from the program/erase sequencer |
| cmp_diff | input | 1 | Latched result of the last compare, 1 when it differed |
| so | output | 1 | Serial status output, changes on falling SCK |
| so_oe | output | 1 | Drive enable for so; 0 means tri-stated |

## Verification
Two functions can meet in the same cycle. One is the capture of a fresh byte for bits 6 down to 0. The other is the live display of the ready bit, and both act on the falling edge that ends bit 7. The bench changes busy and cmp_diff at random in the high phase just before that edge and again in later high phases. It then expects bit 7 to match the value live at sampling time. It expects bits 6 down to 0 to hold the values seen at the capture edge, unaffected by any later change. A parked-clock case toggles busy while bit 7 is held, and checks that the output follows it with no SCK edge.

// File: rtl/stat_pkg.sv
package stat_pkg;

   // default field widths of the status byte
   localparam int DEF_DENS_W = 4;
   localparam int DEF_RSVD_W = 2;

   // phase of the serial output side
   typedef enum logic [1:0] {
      TX_OFF   = 2'd0,
      TX_ARMED = 2'd1,
      TX_SEND  = 2'd2
   } tx_phase_e;

endpackage

// File: rtl/stat_sync.sv
module stat_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic rise,
   output logic fall
);

   logic [STAGES-1:0] pipe;
   logic              last;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[0] <= RST_VAL;
            else        pipe[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= RST_VAL;
            else        pipe[g] <= pipe[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last <= RST_VAL;
      else        last <= pipe[STAGES-1];
   end

   assign q    = pipe[STAGES-1];
   assign rise = pipe[STAGES-1] & ~last;
   assign fall = ~pipe[STAGES-1] & last;

endmodule

// File: rtl/stat_opc_rx.sv
module stat_opc_rx #(
   parameter int             OP_W       = 8,
   parameter logic [OP_W-1:0] OPCODE     = 8'h57,
   parameter logic [OP_W-1:0] OPCODE_ALT = 8'hD7,
   parameter bit             ACCEPT_ALT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel,
   input  logic sck_rise,
   input  logic si,
   output logic hit
);

   localparam int CNT_W = $clog2(OP_W + 1);

   logic [CNT_W-1:0] cnt;
   logic [OP_W-1:0]  shreg;
   logic [OP_W-1:0]  nxt;
   logic             match;

   assign nxt = {shreg[OP_W-2:0], si};

   if (ACCEPT_ALT) begin : g_two_codes
      assign match = (nxt == OPCODE) || (nxt == OPCODE_ALT);
   end else begin : g_one_code
      assign match = (nxt == OPCODE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         shreg <= '0;
         hit   <= 1'b0;
      end else if (!sel) begin
         cnt   <= '0;
         shreg <= '0;
         hit   <= 1'b0;
      end else begin
         hit <= 1'b0;
         if (sck_rise && (cnt < CNT_W'(OP_W))) begin
            shreg <= nxt;
            cnt   <= cnt + 1'b1;
            hit   <= (cnt == CNT_W'(OP_W - 1)) && match;
         end
      end
   end

endmodule

// File: rtl/stat_tx.sv
module stat_tx
   import stat_pkg::*;
#(
   parameter int              DENS_W = DEF_DENS_W,
   parameter int              RSVD_W = DEF_RSVD_W,
   parameter logic [DENS_W-1:0] DENS  = 4'b1011,
   parameter logic [RSVD_W-1:0] RSVD  = 2'b00,
   localparam int             BYTE_W = 2 + DENS_W + RSVD_W,
   localparam int             IDX_W  = $clog2(BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              start,
   input  logic              sck_fall,
   input  logic              busy,
   input  logic              cmp_diff,
   output logic              so,
   output logic              so_oe,
   output logic [IDX_W-1:0]  idx,
   output logic [BYTE_W-1:0] snap
);

   localparam logic [IDX_W-1:0] TOP = IDX_W'(BYTE_W - 1);

   tx_phase_e         phase;
   logic [BYTE_W-1:0] live;

   assign live = {~busy, cmp_diff, DENS, RSVD};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= TX_OFF;
         idx   <= TOP;
         snap  <= '0;
      end else if (!sel) begin
         phase <= TX_OFF;
         idx   <= TOP;
      end else begin
         if (start) phase <= TX_ARMED;
         if (sck_fall) begin
            if (phase == TX_ARMED) begin
               phase <= TX_SEND;
               idx   <= TOP;
            end else if (phase == TX_SEND) begin
               if (idx == '0) idx <= TOP;
               else           idx <= idx - 1'b1;
               if (idx == TOP) snap <= live;
            end
         end
      end
   end

   assign so_oe = (phase == TX_SEND);

   always_comb begin
      if (phase != TX_SEND) so = 1'b0;
      else if (idx == TOP)  so = ~busy;
      else                  so = snap[idx];
   end

endmodule

// File: rtl/stat_stream.sv
module stat_stream
   import stat_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter int                OP_W        = 8,
   parameter logic [OP_W-1:0]   OPCODE      = 8'h57,
   parameter logic [OP_W-1:0]   OPCODE_ALT  = 8'hD7,
   parameter bit                ACCEPT_ALT  = 1'b1,
   parameter int                DENS_W      = DEF_DENS_W,
   parameter int                RSVD_W      = DEF_RSVD_W,
   parameter logic [DENS_W-1:0] DENS        = 4'b1011,
   parameter logic [RSVD_W-1:0] RSVD        = 2'b00
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic si,
   input  logic busy,
   input  logic cmp_diff,
   output logic so,
   output logic so_oe
);

   localparam int BYTE_W = 2 + DENS_W + RSVD_W;
   localparam int IDX_W  = $clog2(BYTE_W);

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 1");
   end
   if (OP_W < 2) begin : g_bad_op
      $error("OP_W must be at least 2");
   end
   if (DENS_W < 1 || RSVD_W < 1) begin : g_bad_fields
      $error("field widths must be at least 1");
   end

   logic cs_q, cs_rise_unused, cs_fall_unused;
   logic sck_q, sck_rise, sck_fall;
   logic si_q, si_rise_unused, si_fall_unused;
   logic sel, hit;
   logic [IDX_W-1:0]  idx;
   logic [BYTE_W-1:0] snap;

   stat_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
      .clk(clk), .rst_n(rst_n), .d(cs_n),
      .q(cs_q), .rise(cs_rise_unused), .fall(cs_fall_unused)
   );

   stat_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
      .clk(clk), .rst_n(rst_n), .d(sck),
      .q(sck_q), .rise(sck_rise), .fall(sck_fall)
   );

   stat_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_si_sync (
      .clk(clk), .rst_n(rst_n), .d(si),
      .q(si_q), .rise(si_rise_unused), .fall(si_fall_unused)
   );

   assign sel = ~cs_q;

   stat_opc_rx #(
      .OP_W(OP_W), .OPCODE(OPCODE), .OPCODE_ALT(OPCODE_ALT), .ACCEPT_ALT(ACCEPT_ALT)
   ) u_rx (
      .clk(clk), .rst_n(rst_n), .sel(sel), .sck_rise(sck_rise), .si(si_q), .hit(hit)
   );

   stat_tx #(
      .DENS_W(DENS_W), .RSVD_W(RSVD_W), .DENS(DENS), .RSVD(RSVD)
   ) u_tx (
      .clk(clk), .rst_n(rst_n), .sel(sel), .start(hit), .sck_fall(sck_fall),
      .busy(busy), .cmp_diff(cmp_diff), .so(so), .so_oe(so_oe),
      .idx(idx), .snap(snap)
   );

endmodule

// File: rtl/stat_stream_chk.sv
module stat_stream_chk #(
   parameter int                DENS_W = 4,
   parameter int                RSVD_W = 2,
   parameter logic [DENS_W-1:0] DENS   = 4'b1011,
   parameter logic [RSVD_W-1:0] RSVD   = 2'b00,
   localparam int               BYTE_W = 2 + DENS_W + RSVD_W,
   localparam int               IDX_W  = $clog2(BYTE_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel,
   input logic              sck_fall,
   input logic              busy,
   input logic              so,
   input logic              so_oe,
   input logic [IDX_W-1:0]  idx,
   input logic [BYTE_W-1:0] snap
);

   localparam logic [IDX_W-1:0] TOP = IDX_W'(BYTE_W - 1);

   a_r8_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> !so_oe);

   a_r3_starts_at_msb: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(so_oe) |-> (idx == TOP));

   a_r3_descends: assert property (@(posedge clk) disable iff (!rst_n)
      (so_oe && sel && sck_fall && idx != '0) |=> (idx == $past(idx) - 1'b1));

   a_r6_wraps_to_msb: assert property (@(posedge clk) disable iff (!rst_n)
      (so_oe && sel && sck_fall && idx == '0) |=> (idx == TOP));

   a_r7_live_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (so_oe && idx == TOP) |-> (so == !busy));

   a_r5_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (so_oe && idx < IDX_W'(RSVD_W)) |-> (so == RSVD[idx]));

   a_r5_density_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (so_oe && idx >= IDX_W'(RSVD_W) && idx < IDX_W'(RSVD_W + DENS_W))
         |-> (so == DENS[idx - IDX_W'(RSVD_W)]));

   a_r9_snapshot_held: assert property (@(posedge clk) disable iff (!rst_n)
      (so_oe && sel && !(sck_fall && idx == TOP)) |=> $stable(snap));

endmodule

bind stat_stream stat_stream_chk #(
   .DENS_W(DENS_W), .RSVD_W(RSVD_W), .DENS(DENS), .RSVD(RSVD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sel(sel), .sck_fall(sck_fall), .busy(busy),
   .so(so), .so_oe(so_oe), .idx(idx), .snap(snap)
);

// File: tb/tb_stat_stream.sv
`timescale 1ns/1ps
module tb_stat_stream;

   localparam int HALF = 8;       // system clocks per SCK half period
   localparam int SYNC = 2;
   localparam int WD   = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
   logic busy = 1'b0, cmp_diff = 1'b0;
   logic so, so_oe;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   stat_stream #(.SYNC_STAGES(SYNC)) dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
      .busy(busy), .cmp_diff(cmp_diff), .so(so), .so_oe(so_oe)
   );

   function automatic logic [7:0] exp_byte(input logic b, input logic c);
      return {~b, c, 4'b1011, 2'b00};
   endfunction

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic select();
      @(negedge clk);
      sck  = 1'b0;
      cs_n = 1'b0;
      wait_clk(HALF);
   endtask

   task automatic deselect();
      @(negedge clk);
      sck = 1'b0;
      wait_clk(HALF);
      cs_n = 1'b1;
      wait_clk(SYNC + 3);
      chk("R8 released", so_oe, 1'b0);
      wait_clk(HALF);
   endtask

   task automatic send_op(input logic [7:0] op);
      for (int k = 7; k >= 0; k--) begin
         @(negedge clk);
         sck = 1'b0;
         si  = op[k];
         wait_clk(HALF);
         sck = 1'b1;
         wait_clk(HALF);
      end
   endtask

   // read one status byte; rnd enables input changes in high phases
   task automatic read_byte(input bit rep, input bit rnd);
      logic sb, sc;
      logic [7:0] e;
      sb = busy;
      sc = cmp_diff;
      for (int i = 7; i >= 0; i--) begin
         @(negedge clk);
         sck = 1'b0;
         if (i == 6) begin
            sb = busy;
            sc = cmp_diff;
         end
         wait_clk(HALF);
         e = exp_byte(sb, sc);
         chk("R3 enable", so_oe, 1'b1);
         if (i == 7)      chk(rep ? "R6 ready repeat" : "R4 ready", so, ~busy);
         else if (i == 6) chk(rep ? "R6 compare repeat" : "R4/R9 compare", so, e[6]);
         else             chk(rep ? "R6 fixed repeat" : "R5 fixed", so, e[i]);
         sck = 1'b1;
         wait_clk(HALF / 2);
         if (rnd) begin
            busy     = $urandom_range(0, 1);
            cmp_diff = $urandom_range(0, 1);
         end
         wait_clk(HALF - HALF / 2);
      end
   endtask

   // non-matching command: output must stay off
   task automatic silent_bits(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sck = 1'b0;
         wait_clk(HALF);
         chk("R2 ignored opcode", so_oe, 1'b0);
         sck = 1'b1;
         busy = $urandom_range(0, 1);
         wait_clk(HALF);
      end
   endtask

   initial begin
      repeat (WD) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] op;
      void'($urandom(32'd20240611));
      wait_clk(4);
      chk("R1 reset oe", so_oe, 1'b0);
      chk("R1 reset so", so, 1'b0);
      rst_n = 1'b1;
      wait_clk(4);
      chk("R1 idle oe", so_oe, 1'b0);

      // directed: both codes, ready and busy
      busy = 1'b0; cmp_diff = 1'b0;
      select(); send_op(8'h57); read_byte(1'b0, 1'b0); deselect();
      busy = 1'b1; cmp_diff = 1'b1;
      select(); send_op(8'hD7); read_byte(1'b0, 1'b0); read_byte(1'b1, 1'b0); deselect();

      // directed: near-miss codes
      select(); send_op(8'h56); silent_bits(10); deselect();
      select(); send_op(8'h17); silent_bits(10); deselect();

      // directed: parked SCK on the ready bit (R7)
      busy = 1'b1;
      select(); send_op(8'h57);
      @(negedge clk);
      sck = 1'b0;
      wait_clk(HALF);
      chk("R7 parked busy", so, 1'b0);
      busy = 1'b0;
      wait_clk(2);
      chk("R7 parked ready", so, 1'b1);
      busy = 1'b1;
      wait_clk(2);
      chk("R7 parked busy again", so, 1'b0);
      busy = 1'b0;
      wait_clk(3 * HALF);
      chk("R7 parked held", so, 1'b1);
      chk("R7 parked oe", so_oe, 1'b1);
      sck = 1'b1;
      wait_clk(HALF);
      cmp_diff = 1'b1;
      begin
         logic [7:0] e;
         e = exp_byte(busy, cmp_diff);
         for (int i = 6; i >= 0; i--) begin
            @(negedge clk);
            sck = 1'b0;
            wait_clk(HALF);
            chk("R6 after park", so, e[i]);
            sck = 1'b1;
            wait_clk(HALF);
         end
      end
      deselect();

      // restart after release (R8)
      busy = 1'b0; cmp_diff = 1'b1;
      select(); send_op(8'hD7); read_byte(1'b0, 1'b0); deselect();

      // random mix
      for (int t = 0; t < 30; t++) begin
         busy     = $urandom_range(0, 1);
         cmp_diff = $urandom_range(0, 1);
         if ($urandom_range(0, 3) == 0) begin
            op = 8'($urandom_range(0, 255));
            if (op[6:0] == 7'h57) op = 8'h00;
            select(); send_op(op); silent_bits(9); deselect();
         end else begin
            op = $urandom_range(0, 1) ? 8'h57 : 8'hD7;
            select();
            send_op(op);
            read_byte(1'b0, 1'b1);
            for (int r = 0; r < int'($urandom_range(0, 2)); r++) read_byte(1'b1, 1'b1);
            deselect();
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule